// File: doc/BRIEF.md
# Stack and Transfer Bus Sequencer

This block produces the bus traffic of an 8-bit core's stack and control-transfer instructions: pushing and popping a register pair, calling a subroutine (always or on a condition), returning, restarting to a fixed low vector, and jumping to an absolute address (always or on a condition). The core hands over the opcode, its current PC and SP, the value of the pair to push, and a flag saying whether the branch condition holds. The block then runs the instruction as a series of fixed-length slots. Each slot either idles or carries exactly one byte read or one byte write at the start of the slot.

At the end of the instruction the block raises a one-cycle completion pulse. In that cycle it presents the next PC, the new SP and, for a pop, the loaded pair value with a load strobe. Stack writes go high byte first, at the higher address. For a call, the two operand bytes are fetched before anything is written to the stack. The read data is combinational from the addressed memory, and the block samples it in the strobe cycle.

Top module: `stk_xfer_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `bus_rd` and `bus_wr` are low until a start is accepted.
- R2: A start is accepted only when the block is idle and the opcode is one of: push 11pp0101, pop 11pp0001, call 0xCD, conditional call 110cc100, return 0xC9, restart 11ttt111, jump 0xC3, conditional jump 110cc010. A start while busy, or a start with any other opcode, is ignored and leaves the outputs and the running instruction untouched.
- R3: Cycles are numbered from 0, the first cycle `busy` is high. Each bus access is a one-cycle strobe in a cycle that is a multiple of 4, `bus_rd` and `bus_wr` are never high together, and `done` is high only in the final busy cycle, after which `busy` drops.
- R4: Push takes 16 cycles. It writes the pair's high byte to SP-1 in cycle 8 and the low byte to SP-2 in cycle 12. The new SP is SP-2 and the next PC is PC+1.
- R5: Pop takes 12 cycles. It reads the low byte from SP in cycle 4 and the high byte from SP+1 in cycle 8. In the last cycle it presents the pair with `pair_load` high, the new SP is SP+2 and the next PC is PC+1. The pair code is (opcode[5:4]+1) mod 4, with 1 = BC, 2 = DE, 3 = HL and 0 = AF.
- R6: When the popped pair code is 0 (AF), bits 3:0 of the loaded low byte read as zero.
- R7: A call (unconditional, or conditional with `cond_ok` high) takes 24 cycles. It reads the target's low byte from PC+1 in cycle 4 and its high byte from PC+2 in cycle 8. It writes (PC+3)[15:8] to SP-1 in cycle 16 and (PC+3)[7:0] to SP-2 in cycle 20. The next PC is the target and the new SP is SP-2.
- R8: Return takes 16 cycles. It reads from SP in cycle 4 and from SP+1 in cycle 8. The next PC is {byte at SP+1, byte at SP} and the new SP is SP+2.
- R9: Restart takes 16 cycles. It writes (PC+1)[15:8] to SP-1 in cycle 8 and (PC+1)[7:0] to SP-2 in cycle 12. The next PC is 0x00 followed by (opcode XOR 0xC7), and the new SP is SP-2.
- R10: A jump (unconditional, or conditional with `cond_ok` high) takes 16 cycles. It reads from PC+1 in cycle 4 and from PC+2 in cycle 8. The next PC is the target and SP is unchanged.
- R11: A conditional call or jump with `cond_ok` low takes 12 cycles with no bus access. The next PC is PC+3 and SP is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the presented instruction |
| opcode | input | 8 | Instruction opcode |
| cond_ok | input | 1 | Branch condition holds for conditional forms |
| pc_in | input | 16 | Address of the instruction's opcode |
| sp_in | input | 16 | Current stack pointer |
| pair_in | input | 16 | Register pair value to push |
| bus_rd_data | input | 8 | Read data for the current address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| bus_rd | output | 1 | Byte read strobe |
| bus_wr | output | 1 | Byte write strobe |
| bus_addr | output | 16 | Bus byte address |
| bus_wr_data | output | 8 | Write data |
| pc_out | output | 16 | Next PC, valid with `done` |
| sp_out | output | 16 | New SP, valid with `done` |
| pair_out | output | 16 | Popped pair value, valid with `done` |
| pair_sel | output | 2 | Pair code of the running push or pop |
| pair_load | output | 1 | Load `pair_out` into the selected pair |

## Verification
The bench uses the default slot length of 4 cycles. At that length every access cycle and total length in the requirements is an exact number the bench can check. The 3-bit slot index covers the six-slot call, which is the longest sequence, so the last slot index is reached. The bench also builds the read data from the address. Because of that, a byte-order or address-offset mistake shows up as a wrong PC or pair value, not as a match that happens by chance.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int SLOT_W = 3;

  typedef enum logic [2:0] {
    K_PUSH, K_POP, K_CALL, K_SKIP, K_RET, K_RST, K_JP
  } kind_t;

  typedef enum logic [2:0] {
    A_IDLE, A_RD_LO, A_RD_HI, A_WR_HI, A_WR_LO
  } act_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  input  logic              cond_ok,
  output logic              valid,
  output kind_t             kind,
  output logic [1:0]        pair_code
);
  always_comb begin
    valid     = 1'b1;
    kind      = K_SKIP;
    pair_code = opcode[5:4] + 2'd1;
    casez (opcode)
      8'b11??0101: kind = K_PUSH;
      8'b11??0001: kind = K_POP;
      8'hCD:       kind = K_CALL;
      8'b110??100: kind = cond_ok ? K_CALL : K_SKIP;
      8'hC9:       kind = K_RET;
      8'b11???111: kind = K_RST;
      8'hC3:       kind = K_JP;
      8'b110??010: kind = cond_ok ? K_JP : K_SKIP;
      default:     valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/stk_slot_timer.sv
module stk_slot_timer #(
  parameter int SLOT_CYCLES = 4,
  parameter int SLOT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  output logic              ph_first,
  output logic              ph_last,
  output logic [SLOT_W-1:0] slot
);
  localparam int PH_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_END = PH_W'(SLOT_CYCLES - 1);

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  assign ph_first = (ph_q == '0);
  assign ph_last  = (ph_q == PH_END);
  assign slot     = slot_q;

  always_comb begin
    ph_d   = ph_q;
    slot_d = slot_q;
    if (load) begin
      ph_d   = '0;
      slot_d = '0;
    end else if (run) begin
      if (ph_last) begin
        ph_d   = '0;
        slot_d = slot_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      slot_q <= '0;
    end else begin
      ph_q   <= ph_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/stk_slot_plan.sv
module stk_slot_plan
  import stk_pkg::*;
(
  input  kind_t             kind,
  input  logic [SLOT_W-1:0] slot,
  output act_t              act,
  output logic              last_slot
);
  logic [SLOT_W-1:0] n_slots;
  logic              reads, writes;

  always_comb begin
    unique case (kind)
      K_PUSH:  n_slots = SLOT_W'(4);
      K_POP:   n_slots = SLOT_W'(3);
      K_CALL:  n_slots = SLOT_W'(6);
      K_SKIP:  n_slots = SLOT_W'(3);
      default: n_slots = SLOT_W'(4);
    endcase
    reads  = (kind == K_POP) || (kind == K_CALL) || (kind == K_RET) || (kind == K_JP);
    writes = (kind == K_PUSH) || (kind == K_CALL) || (kind == K_RST);
    last_slot = (slot == n_slots - 1'b1);
    act = A_IDLE;
    if (reads && slot == SLOT_W'(1))
      act = A_RD_LO;
    else if (reads && slot == SLOT_W'(2))
      act = A_RD_HI;
    else if (writes && slot == n_slots - SLOT_W'(2))
      act = A_WR_HI;
    else if (writes && last_slot)
      act = A_WR_LO;
  end
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         opcode,
  input  logic               cond_ok,
  input  logic [15:0]        pc_in,
  input  logic [15:0]        sp_in,
  input  logic [15:0]        pair_in,
  input  logic [7:0]         bus_rd_data,
  output logic               busy,
  output logic               done,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [15:0]        bus_addr,
  output logic [7:0]         bus_wr_data,
  output logic [15:0]        pc_out,
  output logic [15:0]        sp_out,
  output logic [15:0]        pair_out,
  output logic [1:0]         pair_sel,
  output logic               pair_load
);
  logic [1:0] rsync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  logic              dec_valid;
  kind_t             dec_kind;
  logic [1:0]        dec_pair;
  logic              ph_first, ph_last, last_slot;
  logic [SLOT_W-1:0] slot;
  act_t              act;

  logic              busy_q, busy_d;
  kind_t             kind_q, kind_d;
  logic [1:0]        sel_q, sel_d;
  logic [DATA_W-1:0] op_q, op_d, lo_q, lo_d, hi_q, hi_d;
  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d, val_q, val_d;

  logic launch, finish, strobe;
  logic [ADDR_W-1:0] rd_base, push_val;

  stk_decode u_dec (
    .opcode(opcode), .cond_ok(cond_ok),
    .valid(dec_valid), .kind(dec_kind), .pair_code(dec_pair)
  );

  stk_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .SLOT_W(SLOT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .load(launch), .run(busy_q),
    .ph_first(ph_first), .ph_last(ph_last), .slot(slot)
  );

  stk_slot_plan u_plan (
    .kind(kind_q), .slot(slot), .act(act), .last_slot(last_slot)
  );

  assign launch = start && !busy_q && dec_valid;
  assign finish = busy_q && ph_last && last_slot;
  assign strobe = busy_q && ph_first && (act != A_IDLE);

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    sel_d  = sel_q;
    op_d   = op_q;
    pc_d   = pc_q;
    sp_d   = sp_q;
    val_d  = val_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (launch) begin
      busy_d = 1'b1;
      kind_d = dec_kind;
      sel_d  = dec_pair;
      op_d   = opcode;
      pc_d   = pc_in;
      sp_d   = sp_in;
      val_d  = pair_in;
    end else if (finish) begin
      busy_d = 1'b0;
    end
    if (strobe && act == A_RD_LO) lo_d = bus_rd_data;
    if (strobe && act == A_RD_HI) hi_d = bus_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      kind_q <= K_PUSH;
      sel_q  <= '0;
      op_q   <= '0;
      pc_q   <= '0;
      sp_q   <= '0;
      val_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      sel_q  <= sel_d;
      op_q   <= op_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      val_q  <= val_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  // Bus side: stack reads use SP, operand reads use the bytes after the opcode.
  always_comb begin
    rd_base = ((kind_q == K_POP) || (kind_q == K_RET)) ? sp_q : pc_q + 16'd1;
    unique case (kind_q)
      K_CALL:  push_val = pc_q + 16'd3;
      K_RST:   push_val = pc_q + 16'd1;
      default: push_val = val_q;
    endcase
    bus_addr    = '0;
    bus_wr_data = '0;
    unique case (act)
      A_RD_LO: bus_addr = rd_base;
      A_RD_HI: bus_addr = rd_base + 16'd1;
      A_WR_HI: begin bus_addr = sp_q - 16'd1; bus_wr_data = push_val[15:8]; end
      A_WR_LO: begin bus_addr = sp_q - 16'd2; bus_wr_data = push_val[7:0];  end
      default: ;
    endcase
  end

  assign bus_rd = strobe && ((act == A_RD_LO) || (act == A_RD_HI));
  assign bus_wr = strobe && ((act == A_WR_HI) || (act == A_WR_LO));

  // Results, valid with done.
  always_comb begin
    unique case (kind_q)
      K_CALL, K_JP, K_RET: pc_out = {hi_q, lo_q};
      K_RST:               pc_out = {8'h00, op_q ^ 8'hC7};
      K_SKIP:              pc_out = pc_q + 16'd3;
      default:             pc_out = pc_q + 16'd1;
    endcase
    unique case (kind_q)
      K_PUSH, K_CALL, K_RST: sp_out = sp_q - 16'd2;
      K_POP, K_RET:          sp_out = sp_q + 16'd2;
      default:               sp_out = sp_q;
    endcase
  end

  assign pair_out  = {hi_q, (sel_q == 2'd0) ? (lo_q & 8'hF0) : lo_q};
  assign pair_sel  = sel_q;
  assign pair_load = finish && (kind_q == K_POP);
  assign busy      = busy_q;
  assign done      = finish;
endmodule

// File: rtl/stk_xfer_seq_chk.sv
module stk_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       pair_load,
  input logic [1:0] pair_sel,
  input logic [3:0] pair_lo_nib
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R3
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> busy); // R3
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> !(bus_rd || bus_wr)); // R3
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R3
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_LAUNCH_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
  AST_LOAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |-> done); // R5
  AST_AF_NIBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_load && pair_sel == 2'd0) |-> (pair_lo_nib == 4'h0)); // R6
endmodule

bind stk_xfer_seq stk_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .pair_load(pair_load),
  .pair_sel(pair_sel), .pair_lo_nib(pair_out[3:0])
);

// File: tb/stk_xfer_seq_tb.sv
module stk_xfer_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic cond_ok = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, pair_in = '0;
  logic [7:0] bus_rd_data;
  logic busy, done, bus_rd, bus_wr, pair_load;
  logic [15:0] bus_addr, pc_out, sp_out, pair_out;
  logic [7:0] bus_wr_data;
  logic [1:0] pair_sel;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign bus_rd_data = mem(bus_addr);

  stk_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .cond_ok(cond_ok),
    .pc_in(pc_in), .sp_in(sp_in), .pair_in(pair_in), .bus_rd_data(bus_rd_data),
    .busy(busy), .done(done), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wr_data(bus_wr_data), .pc_out(pc_out),
    .sp_out(sp_out), .pair_out(pair_out), .pair_sel(pair_sel), .pair_load(pair_load)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  int cyc, ev_n, done_n, done_cyc, stray_n;
  logic        ev_wr[8];
  int          ev_cyc[8];
  logic [15:0] ev_addr[8];
  logic [7:0]  ev_data[8];
  logic [15:0] cap_pc, cap_sp, cap_pair;
  logic [1:0]  cap_sel;
  logic        cap_load;

  always @(negedge clk) begin
    if (!busy && (bus_rd || bus_wr || done)) stray_n++;
    if (busy) begin
      if (bus_rd || bus_wr) begin
        if (ev_n < 8) begin
          ev_wr[ev_n]   = bus_wr;
          ev_cyc[ev_n]  = cyc;
          ev_addr[ev_n] = bus_addr;
          ev_data[ev_n] = bus_wr ? bus_wr_data : bus_rd_data;
        end
        ev_n++;
      end
      if (done) begin
        done_n++;
        done_cyc = cyc;
        cap_pc = pc_out; cap_sp = sp_out; cap_pair = pair_out;
        cap_sel = pair_sel; cap_load = pair_load;
      end
      cyc++;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int i, input logic wr, input int c,
                        input logic [15:0] a, input logic [7:0] d);
    check(req, $sformatf("event %0d", i),
          {31'd0, ev_wr[i], ev_cyc[i][7:0], ev_addr[i], ev_data[i]},
          {31'd0, wr, c[7:0], a, d});
  endtask

  // Runs one instruction; optional second start pulse (mid_en) while busy.
  task automatic run_op(input logic [7:0] op, input logic c, input logic [15:0] pc,
                        input logic [15:0] sp, input logic [15:0] pr,
                        input bit mid_en, input logic [7:0] mid_op);
    int guard = 0;
    @(negedge clk);
    ev_n = 0; cyc = 0; done_n = 0; done_cyc = -1; stray_n = 0;
    opcode = op; cond_ok = c; pc_in = pc; sp_in = sp; pair_in = pr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_en) begin
      repeat (3) @(negedge clk);
      opcode = mid_op; cond_ok = 1'b1; pc_in = 16'h7777; sp_in = 16'h8888;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_n == 0 && guard < 100) begin
      @(posedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "busy", {63'd0, busy}, 64'd0);
    check("R1", "done", {63'd0, done}, 64'd0);
    check("R1", "strobes", {62'd0, bus_rd, bus_wr}, 64'd0);
  endtask

  task automatic t_push(input logic [7:0] op, input logic [15:0] pc,
                        input logic [15:0] sp, input logic [15:0] pr, input logic [1:0] code);
    run_op(op, 1'b0, pc, sp, pr, 0, 8'h00);
    check("R4", "events", ev_n, 2);
    chk_ev("R4", 0, 1'b1, 8, sp - 16'd1, pr[15:8]);
    chk_ev("R4", 1, 1'b1, 12, sp - 16'd2, pr[7:0]);
    check("R3", "push length", done_cyc, 15);
    check("R4", "sp", cap_sp, sp - 16'd2);
    check("R4", "pc", cap_pc, pc + 16'd1);
    check("R5", "pair code", cap_sel, code);
    check("R4", "no load", cap_load, 0);
    check("R3", "idle after", {63'd0, busy}, 0);
  endtask

  task automatic t_pop(input logic [7:0] op, input logic [15:0] sp, input logic [1:0] code);
    logic [7:0] lo;
    run_op(op, 1'b0, 16'h0200, sp, 16'h0000, 0, 8'h00);
    lo = mem(sp);
    if (code == 2'd0) lo = lo & 8'hF0; // R6
    check("R5", "events", ev_n, 2);
    chk_ev("R5", 0, 1'b0, 4, sp, mem(sp));
    chk_ev("R5", 1, 1'b0, 8, sp + 16'd1, mem(sp + 16'd1));
    check("R3", "pop length", done_cyc, 11);
    check(code == 2'd0 ? "R6" : "R5", "pair value", cap_pair, {mem(sp + 16'd1), lo});
    check("R5", "load", cap_load, 1);
    check("R5", "pair code", cap_sel, code);
    check("R5", "sp", cap_sp, sp + 16'd2);
    check("R5", "pc", cap_pc, 16'h0201);
  endtask

  task automatic t_call(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] sp);
    logic [15:0] ret;
    ret = pc + 16'd3;
    run_op(op, 1'b1, pc, sp, 16'h0000, 0, 8'h00);
    check("R7", "events", ev_n, 4);
    chk_ev("R7", 0, 1'b0, 4, pc + 16'd1, mem(pc + 16'd1));
    chk_ev("R7", 1, 1'b0, 8, pc + 16'd2, mem(pc + 16'd2));
    chk_ev("R7", 2, 1'b1, 16, sp - 16'd1, ret[15:8]);
    chk_ev("R7", 3, 1'b1, 20, sp - 16'd2, ret[7:0]);
    check("R3", "call length", done_cyc, 23);
    check("R7", "pc", cap_pc, {mem(pc + 16'd2), mem(pc + 16'd1)});
    check("R7", "sp", cap_sp, sp - 16'd2);
  endtask

  task automatic t_ret;
    run_op(8'hC9, 1'b0, 16'h0500, 16'hCFF0, 16'h0000, 0, 8'h00);
    check("R8", "events", ev_n, 2);
    chk_ev("R8", 0, 1'b0, 4, 16'hCFF0, mem(16'hCFF0));
    chk_ev("R8", 1, 1'b0, 8, 16'hCFF1, mem(16'hCFF1));
    check("R3", "ret length", done_cyc, 15);
    check("R8", "pc", cap_pc, {mem(16'hCFF1), mem(16'hCFF0)});
    check("R8", "sp", cap_sp, 16'hCFF2);
  endtask

  task automatic t_rst(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] sp);
    logic [15:0] ret;
    ret = pc + 16'd1;
    run_op(op, 1'b0, pc, sp, 16'h0000, 0, 8'h00);
    check("R9", "events", ev_n, 2);
    chk_ev("R9", 0, 1'b1, 8, sp - 16'd1, ret[15:8]);
    chk_ev("R9", 1, 1'b1, 12, sp - 16'd2, ret[7:0]);
    check("R9", "length", done_cyc, 15);
    check("R9", "vector", cap_pc, {8'h00, op ^ 8'hC7});
    check("R9", "sp", cap_sp, sp - 16'd2);
  endtask

  task automatic t_jp(input logic [7:0] op, input logic [15:0] pc);
    run_op(op, 1'b1, pc, 16'hE000, 16'h0000, 0, 8'h00);
    check("R10", "events", ev_n, 2);
    chk_ev("R10", 0, 1'b0, 4, pc + 16'd1, mem(pc + 16'd1));
    chk_ev("R10", 1, 1'b0, 8, pc + 16'd2, mem(pc + 16'd2));
    check("R10", "length", done_cyc, 15);
    check("R10", "pc", cap_pc, {mem(pc + 16'd2), mem(pc + 16'd1)});
    check("R10", "sp", cap_sp, 16'hE000);
  endtask

  task automatic t_skip(input logic [7:0] op);
    run_op(op, 1'b0, 16'h4100, 16'hDF00, 16'h0000, 0, 8'h00);
    check("R11", "events", ev_n, 0);
    check("R11", "length", done_cyc, 11);
    check("R11", "pc", cap_pc, 16'h4103);
    check("R11", "sp", cap_sp, 16'hDF00);
  endtask

  task automatic t_busy_start;
    run_op(8'hD5, 1'b0, 16'h1000, 16'hFFF0, 16'hA1B2, 1, 8'hC9);
    check("R2", "events", ev_n, 2);
    chk_ev("R2", 0, 1'b1, 8, 16'hFFEF, 8'hA1);
    check("R2", "done count", done_n, 1);
    check("R2", "pc", cap_pc, 16'h1001);
    check("R2", "sp", cap_sp, 16'hFFEE);
    check("R2", "no relaunch", {63'd0, busy}, 0);
  endtask

  task automatic t_bad_opcode;
    @(negedge clk);
    stray_n = 0;
    opcode = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opcode = 8'hD3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "bad op busy", {63'd0, busy}, 0);
    repeat (4) @(negedge clk);
    check("R2", "bad op activity", stray_n, 0);
    check("R2", "bad op idle", {61'd0, busy, bus_rd, bus_wr}, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_push(8'hD5, 16'h1234, 16'hFFFE, 16'hBEEF, 2'd2);
    t_push(8'hF5, 16'h0040, 16'hC000, 16'h12F3, 2'd0);
    t_pop(8'hC1, 16'hD010, 2'd1);
    t_pop(8'hF1, 16'hD0A0, 2'd0);
    t_pop(8'hE1, 16'hC1FE, 2'd3);
    t_call(8'hCD, 16'h0150, 16'hFFFE);
    t_call(8'hC4, 16'h20FE, 16'hD800);
    t_ret();
    t_rst(8'hFF, 16'h0400, 16'hFFFE);
    t_rst(8'hC7, 16'h12FF, 16'hA000);
    t_jp(8'hC3, 16'h3000);
    t_jp(8'hDA, 16'h55FF);
    t_skip(8'hCC);
    t_skip(8'hD2);
    t_busy_start();
    t_bad_opcode();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule